// File: doc/BRIEF.md
# Late-Write Synchronous SRAM Core

A single-port synchronous memory whose write data lags its address by one clock. At each rising edge the block samples chip select, write strobe, byte enables and address. For a write, the address and lane mask are taken at that edge and the data word at the next edge. The pending write waits in a one-entry buffer. It is committed to the array only when the next real write is accepted, so the array port is used once per write and never competes with a read.

Reads compare their address against the buffered write. On a hit, the enabled 9-bit lanes of the buffered word replace the array lanes, so a read always returns the newest data, even when it directly follows the write it reads. A read result is registered at the edge that samples the read address and is shown through the following clock period. An asynchronous, active-low output enable qualifies the result without any clock edge. A write cycle or a deselected cycle blanks the output at the edge that samples it.

Top module: `lwsram_core`

## Requirements
- R1: After synchronous reset, `rvalid` is 0 and `rdata` is all zeros.
- R2: A write whose control is sampled at edge k takes its address at edge k and its data from `wdata` at edge k+1. A later read of that address returns the data.
- R3: A read sampled at the edge where the preceding write's data is captured, or at any later edge, returns the written word. No stale array data is returned, and no idle cycle is needed between the two.
- R4: Lane i covers `wdata`/`rdata` bits [9i+8:9i] and is written only when `be_n[i]` is 0 in the write cycle. The other lanes keep their old value, both in reads served from the buffer and in reads served after the commit.
- R5: A write cycle with every `be_n` bit at 1 changes no stored data and blanks the output for the following period.
- R6: After an edge that samples a write cycle (`cs_n`=0, `we_n`=0), `rvalid` is 0 until the next edge.
- R7: After an edge that samples `cs_n`=1, `rvalid` is 0 until the next edge, and nothing is written.
- R8: `oe_n`=1 forces `rvalid` to 0 and `rdata` to zero at once, with no clock edge. Returning `oe_n` to 0 restores the held read result.
- R9: `be_n` has no effect on read cycles. All lanes are returned whatever its value.
- R10: Back-to-back writes, to the same or to different addresses, each commit their own lanes. Reads afterwards see the final values.
- R11: After an edge that samples a read (`cs_n`=0, `we_n`=1) with `oe_n`=0, `rvalid` is 1 and `rdata` holds the word at that address until the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cs_n | input | 1 | Chip select, active low, sampled |
| we_n | input | 1 | Write strobe, active low, sampled |
| be_n | input | DATA_W/9 | Byte lane write enables, active low, sampled |
| addr | input | $clog2(DEPTH) | Word address, sampled |
| wdata | input | DATA_W | Write data, sampled one edge after its address |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| rdata | output | DATA_W | Read data, zero when not valid |
| rvalid | output | 1 | Read data valid |

## Verification
The bench keeps the default 18-bit width (two lanes) and shrinks DEPTH to 16. It first fills every address with full-word writes, so no read ever depends on an uninitialised lane. The small depth lets it use the whole address space in sequences of consecutive writes that commit each other. Same-address and different-address pairs land within a few cycles of each other, so buffer hits, misses, partial-lane merges and commits all occur close together.

// File: rtl/lwsram_pkg.sv
// Package: shared constants and types for the late-write SRAM core.
// Assumes a lane is always 9 bits; the data width is a multiple of it.
package lwsram_pkg;
    localparam int LANE_W = 9;

    // Kind of cycle sampled at a rising edge
    typedef enum logic [1:0] {
        CYC_IDLE   = 2'd0,
        CYC_READ   = 2'd1,
        CYC_WRITE  = 2'd2,
        CYC_NULLWR = 2'd3
    } cyc_e;
endpackage

// File: rtl/lwsram_ctl.sv
// Module: cycle decoder. Turns the sampled control pins into a cycle
// kind, a read enable, a write enable and an active-high lane mask.
// Assumes the inputs are stable around the clock edge.
module lwsram_ctl #(
    parameter int LANES = 2
) (
    input  logic                 cs_n,
    input  logic                 we_n,
    input  logic [LANES-1:0]     be_n,
    output lwsram_pkg::cyc_e     cyc,
    output logic                 rd_en,
    output logic                 wr_en,
    output logic [LANES-1:0]     wr_mask
);
    import lwsram_pkg::*;

    // Decode one cycle from chip select, write strobe and lane enables
    always_comb begin
        wr_mask = ~be_n;
        rd_en   = 1'b0;
        wr_en   = 1'b0;
        if (cs_n) begin
            cyc = CYC_IDLE;
        end else if (we_n) begin
            cyc   = CYC_READ;
            rd_en = 1'b1;
        end else if (|wr_mask) begin
            cyc   = CYC_WRITE;
            wr_en = 1'b1;
        end else begin
            cyc = CYC_NULLWR;
        end
    end
endmodule

// File: rtl/lwsram_wbuf.sv
// Module: one-entry late-write buffer. Takes address and lane mask at
// the write edge and the data at the next edge. Releases the entry to
// the array when the next real write is accepted.
// Assumes wr_en is already qualified by chip select and a non-empty mask.
module lwsram_wbuf #(
    parameter int AW    = 8,
    parameter int LANES = 2,
    parameter int DW    = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LANES-1:0]  wr_mask,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic              buf_valid,
    output logic [AW-1:0]     buf_addr,
    output logic [LANES-1:0]  buf_mask,
    output logic [DW-1:0]     buf_data,
    output logic              commit_en
);
    logic          data_pend;
    logic [DW-1:0] data_q;

    // Data that belongs to the entry: arriving now or already stored
    always_comb begin
        buf_data  = data_pend ? wdata : data_q;
        commit_en = wr_en && buf_valid;
    end

    // Hold the entry state and the flags for valid entry and awaited data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_valid <= 1'b0;
            data_pend <= 1'b0;
        end else begin
            if (wr_en) begin
                buf_valid <= 1'b1;
                data_pend <= 1'b1;
            end else begin
                data_pend <= 1'b0;
            end
        end
    end

    // Capture address and mask at the write edge, data one edge later
    always_ff @(posedge clk) begin
        if (data_pend) begin
            data_q <= wdata;
        end
        if (wr_en) begin
            buf_addr <= addr;
            buf_mask <= wr_mask;
        end
    end

    AST_PEND_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        data_pend |-> $past(wr_en)); // R2

    AST_NULL_WRITE_KEEPS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && buf_valid) |=> ($stable(buf_addr) && $stable(buf_mask))); // R5

    AST_ENTRY_STAYS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        buf_valid |=> buf_valid); // R10
endmodule

// File: rtl/lwsram_array.sv
// Module: storage array split into independent 9-bit lane memories,
// each with its own write enable; one write port, one combinational
// read port. Contents are not reset.
module lwsram_array #(
    parameter int DEPTH = 256,
    parameter int AW    = 8,
    parameter int LANES = 2
) (
    input  logic                                 clk,
    input  logic                                 we,
    input  logic [LANES-1:0]                     wmask,
    input  logic [AW-1:0]                        waddr,
    input  logic [LANES*lwsram_pkg::LANE_W-1:0]  wdata,
    input  logic [AW-1:0]                        raddr,
    output logic [LANES*lwsram_pkg::LANE_W-1:0]  rdata
);
    import lwsram_pkg::*;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];

        // Write this lane when its mask bit is set in a commit
        always_ff @(posedge clk) begin
            if (we && wmask[l]) begin
                mem[waddr] <= wdata[l*LANE_W +: LANE_W];
            end
        end

        // Read this lane at the presented address
        always_comb begin
            rdata[l*LANE_W +: LANE_W] = mem[raddr];
        end
    end
endmodule

// File: rtl/lwsram_rdpath.sv
// Module: read path. Merges buffered lanes over the array word on an
// address hit, registers the result on a read edge and blanks it on
// any other edge. Output enable gates the result asynchronously.
module lwsram_rdpath #(
    parameter int AW    = 8,
    parameter int LANES = 2,
    parameter int DW    = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lwsram_pkg::cyc_e  cyc,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     arr_word,
    input  logic              buf_valid,
    input  logic [AW-1:0]     buf_addr,
    input  logic [LANES-1:0]  buf_mask,
    input  logic [DW-1:0]     buf_data,
    input  logic              oe_n,
    output logic [DW-1:0]     rdata,
    output logic              rvalid
);
    import lwsram_pkg::*;

    logic          hit;
    logic [DW-1:0] merged;
    logic [DW-1:0] out_q;
    logic          out_v;

    // Compare the read address with the buffered write address
    always_comb begin
        hit = buf_valid && (buf_addr == addr);
    end

    for (genvar l = 0; l < LANES; l++) begin : g_merge
        // Pick the buffered lane on a hit with that lane enabled
        always_comb begin
            merged[l*LANE_W +: LANE_W] = (hit && buf_mask[l]) ?
                buf_data[l*LANE_W +: LANE_W] : arr_word[l*LANE_W +: LANE_W];
        end
    end

    // Register the read result; any non-read edge clears the flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_v <= 1'b0;
            out_q <= '0;
        end else begin
            out_v <= rd_en;
            if (rd_en) begin
                out_q <= merged;
            end
        end
    end

    // Apply the asynchronous output enable
    always_comb begin
        rvalid = out_v && !oe_n;
        rdata  = rvalid ? out_q : '0;
    end

    AST_WRITE_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cyc) == CYC_WRITE || $past(cyc) == CYC_NULLWR) |-> !rvalid); // R6

    AST_CS_DESELECTS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cyc) == CYC_IDLE) |-> !rvalid); // R7

    AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rvalid |-> $past(rd_en)); // R11
endmodule

// File: rtl/lwsram_core.sv
// Module: top of the late-write SRAM core. Wires the decoder, the
// write buffer, the lane array and the read path together.
// Assumes DATA_W is a multiple of 9 and DEPTH is at least 2.
module lwsram_core #(
    parameter int DATA_W = 18,
    parameter int DEPTH  = 256,
    localparam int LANES = DATA_W / lwsram_pkg::LANE_W,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic [LANES-1:0]  be_n,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              oe_n,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    import lwsram_pkg::*;

    cyc_e              cyc;
    logic              rd_en;
    logic              wr_en;
    logic [LANES-1:0]  wr_mask;
    logic              buf_valid;
    logic [AW-1:0]     buf_addr;
    logic [LANES-1:0]  buf_mask;
    logic [DATA_W-1:0] buf_data;
    logic              commit_en;
    logic [DATA_W-1:0] arr_word;

    lwsram_ctl #(.LANES(LANES)) u_ctl (
        .cs_n    (cs_n),
        .we_n    (we_n),
        .be_n    (be_n),
        .cyc     (cyc),
        .rd_en   (rd_en),
        .wr_en   (wr_en),
        .wr_mask (wr_mask)
    );

    lwsram_wbuf #(.AW(AW), .LANES(LANES), .DW(DATA_W)) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_mask   (wr_mask),
        .addr      (addr),
        .wdata     (wdata),
        .buf_valid (buf_valid),
        .buf_addr  (buf_addr),
        .buf_mask  (buf_mask),
        .buf_data  (buf_data),
        .commit_en (commit_en)
    );

    lwsram_array #(.DEPTH(DEPTH), .AW(AW), .LANES(LANES)) u_array (
        .clk   (clk),
        .we    (commit_en),
        .wmask (buf_mask),
        .waddr (buf_addr),
        .wdata (buf_data),
        .raddr (addr),
        .rdata (arr_word)
    );

    lwsram_rdpath #(.AW(AW), .LANES(LANES), .DW(DATA_W)) u_rdpath (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc       (cyc),
        .rd_en     (rd_en),
        .addr      (addr),
        .arr_word  (arr_word),
        .buf_valid (buf_valid),
        .buf_addr  (buf_addr),
        .buf_mask  (buf_mask),
        .buf_data  (buf_data),
        .oe_n      (oe_n),
        .rdata     (rdata),
        .rvalid    (rvalid)
    );

    AST_RDATA_QUIET_WHEN_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == '0)); // R8

    AST_READ_WRITE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && commit_en)); // R3
endmodule

// File: tb/lwsram_core_bench.sv
`timescale 1ns/1ps
module lwsram_core_bench;
    localparam int DW    = 18;
    localparam int DEPTH = 16;
    localparam int AW    = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          we_n = 1'b1;
    logic [1:0]    be_n = 2'b11;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          oe_n = 1'b0;
    logic [DW-1:0] rdata;
    logic          rvalid;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // Behavioural reference: memory plus one write awaiting its data
    logic [DW-1:0] ref_mem [DEPTH];
    bit            pend_v = 0;
    int            pend_a = 0;
    logic [1:0]    pend_m = '0;
    logic [DW-1:0] exp_d = '0;
    bit            exp_v = 0;

    always #2.5 clk = ~clk;

    lwsram_core #(.DATA_W(DW), .DEPTH(DEPTH)) u_lwsram_core (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .be_n(be_n),
        .addr(addr), .wdata(wdata), .oe_n(oe_n), .rdata(rdata), .rvalid(rvalid)
    );

    task automatic check(input bit ok, input string req, input logic [DW:0] act,
                         input logic [DW:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_out(input string req);
        logic [DW-1:0] ed;
        bit ev;
        ev = exp_v && !oe_n;
        ed = ev ? exp_d : '0;
        check(rvalid == ev && rdata == ed, req, {rvalid, rdata}, {ev, ed});
    endtask

    // One clock: drive at the falling edge, update the model at the rising edge
    task automatic step(input bit c, input bit w, input logic [1:0] b, input int a,
                        input logic [DW-1:0] wd, input string req);
        @(negedge clk);
        cs_n = c; we_n = w; be_n = b; addr = AW'(a); wdata = wd;
        @(posedge clk);
        if (pend_v) begin
            if (pend_m[0]) ref_mem[pend_a][8:0]  = wd[8:0];
            if (pend_m[1]) ref_mem[pend_a][17:9] = wd[17:9];
            pend_v = 0;
        end
        exp_v = (!c && w);
        if (exp_v) exp_d = ref_mem[a];
        if (!c && !w && b != 2'b11) begin
            pend_v = 1; pend_a = a; pend_m = ~b;
        end
        #1;
        compare_out(req);
    endtask

    task automatic rd(input int a, input logic [1:0] b, input logic [DW-1:0] wd,
                      input string req);
        step(1'b0, 1'b1, b, a, wd, req);
    endtask

    task automatic wr(input int a, input logic [1:0] b, input logic [DW-1:0] wd,
                      input string req);
        step(1'b0, 1'b0, b, a, wd, req);
    endtask

    function automatic logic [DW-1:0] pat(input int a);
        return DW'(18'h2A5A5 ^ (a * 18'h0F0F3));
    endfunction

    initial begin
        #1000000;
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        #1;
        check(rvalid == 1'b0 && rdata == '0, "R1", {rvalid, rdata}, '0);
        @(negedge clk); rst_n = 1'b1;

        // R10/R2: fill every address with consecutive full writes
        for (int a = 0; a < DEPTH; a++) begin
            wr(a, 2'b00, (a == 0) ? '0 : pat(a - 1), "R6");
        end
        step(1'b1, 1'b1, 2'b11, 0, pat(DEPTH - 1), "R7");

        // R2/R9: read everything back with alternating lane enables
        for (int a = 0; a < DEPTH; a++) begin
            rd(a, (a % 2 == 0) ? 2'b00 : 2'b11, '0, "R2_R9");
        end

        // R3: read right at the data edge of the write, then again later
        wr(5, 2'b00, '0, "R6");
        rd(5, 2'b01, 18'h1ABCD, "R3");
        rd(5, 2'b00, '0, "R3");

        // R4: partial writes to one lane, read from buffer and after commit
        wr(7, 2'b10, '0, "R4");
        rd(7, 2'b00, 18'h3FFFF, "R4");
        wr(8, 2'b01, '0, "R4");
        rd(7, 2'b00, 18'h00155, "R4");
        rd(8, 2'b00, '0, "R4");
        wr(2, 2'b00, '0, "R4");
        rd(8, 2'b11, 18'h0F00F, "R4");

        // R5: null write changes nothing and blanks the output
        wr(9, 2'b11, '0, "R5");
        rd(9, 2'b00, 18'h3FFFF, "R5");
        rd(2, 2'b00, '0, "R5");

        // R7: deselect after a read blanks at once and writes nothing
        rd(3, 2'b00, '0, "R11");
        step(1'b1, 1'b0, 2'b00, 3, '0, "R7");
        rd(3, 2'b00, 18'h12345, "R7");

        // R10: back-to-back writes to the same address, then a different one
        wr(11, 2'b00, '0, "R10");
        wr(11, 2'b01, 18'h11111, "R10");
        wr(12, 2'b00, 18'h22222, "R10");
        rd(11, 2'b00, 18'h33333, "R10");
        rd(12, 2'b00, '0, "R10");
        wr(11, 2'b10, '0, "R10");
        wr(12, 2'b10, 18'h00ABC, "R10");
        step(1'b1, 1'b1, 2'b11, 0, 18'h00DEF, "R7");
        rd(11, 2'b00, '0, "R10");
        rd(12, 2'b00, '0, "R10");

        // R8: output enable acts with no clock edge
        rd(4, 2'b00, '0, "R11");
        @(negedge clk);
        cs_n = 1'b0; we_n = 1'b1; addr = 4'd6;
        #0.5 oe_n = 1'b1; #0.2;
        check(rvalid == 1'b0 && rdata == '0, "R8", {rvalid, rdata}, '0);
        @(posedge clk);
        exp_v = 1; exp_d = ref_mem[6];
        #1;
        compare_out("R8");
        oe_n = 1'b0; #0.2;
        compare_out("R8");
        rd(6, 2'b00, '0, "R11");

        // R6: write following a read blanks the output
        wr(13, 2'b00, '0, "R6");
        step(1'b1, 1'b1, 2'b11, 0, 18'h0C0DE, "R6");
        rd(13, 2'b00, '0, "R2");

        // R2/R4 sweep across all addresses
        for (int a = 0; a < DEPTH; a++) begin
            rd(a, 2'b00, '0, "R2");
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule